// File: doc/BRIEF.md
# Multi-Cycle Warp Issue Sequencer

This block spreads one decoded instruction over a thread bundle that is wider than the row of SIMD functional units beneath it. It holds the instruction for several consecutive clocks, and in each clock it names the slice of threads being served. The slice is a group of threads equal in size to the unit count. For each slice it also gives a per-unit write enable, taken from the bundle's active-thread mask. On the last slice it raises a one-cycle completion pulse, and then it reopens for the next instruction.

Two bundle widths are supported. The wide one is used for fragment work and the narrow one for vertex work, and a mode input picks between them when an instruction is accepted. The number of clocks an instruction occupies is the bundle width divided by the unit count. With the defaults, a fragment bundle of 32 threads on 8 units takes 4 clocks, and a vertex bundle of 16 threads takes 2 clocks. Other configurations, such as 32 threads on 16 units or 64 threads on 16 units, follow from the parameters. The arithmetic datapath is outside this block.

Top module: `ws_warp_issue_seq`

## Requirements
- R1: During and directly after reset, `instr_ready` is 1, and `slice_vld`, `done` and `lane_en` are all 0.
- R2: An instruction is accepted in a cycle where `instr_valid` and `instr_ready` are both 1. The first slice, with `slice_idx` = 0, appears in the next cycle.
- R3: When `vtx_mode` = 0 at acceptance, the block issues FRAG_BUNDLE/UNITS slices (4 by default) in consecutive cycles, with `slice_idx` counting 0, 1, 2 and 3.
- R4: When `vtx_mode` = 1 at acceptance, the block issues VTX_BUNDLE/UNITS slices (2 by default) in consecutive cycles, with `slice_idx` counting 0 and 1.
- R5: `done` is 1 for exactly one cycle per instruction, in the cycle of its last slice, and is 0 in every other cycle.
- R6: `instr_ready` is 0 from the first slice through the `done` cycle. While it is 0, `instr_valid` has no effect.
- R7: In slice k, `lane_en[u]` equals bit k*UNITS+u of `active_mask` as it was captured at acceptance. `lane_en` is 0 in every cycle without a slice. Changes to `active_mask` after acceptance have no effect.
- R8: In vertex mode, bits of `active_mask` at or above VTX_BUNDLE have no effect on `lane_en`.
- R9: `instr_ready` returns to 1 in the cycle after `done`. When `instr_valid` is held at 1, consecutive instructions therefore complete (slices+1) cycles apart.
- R10: The mode is sampled only at acceptance. Changes to `vtx_mode` during issue do not change the slice count in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | An instruction is offered |
| vtx_mode | input | 1 | 1 selects the narrow (vertex) bundle, 0 the wide (fragment) bundle |
| active_mask | input | FRAG_BUNDLE | Per-thread active bits for the offered instruction |
| instr_ready | output | 1 | The block can accept an instruction this cycle |
| slice_vld | output | 1 | A slice is being issued this cycle |
| slice_idx | output | IDX_W | Index of the slice being issued |
| lane_en | output | UNITS | Per-unit write enable for the current slice |
| done | output | 1 | Last slice of the bundle is issued this cycle |

## Verification
The cases of interest are those where two functions meet in one cycle. The last slice's lane enables and the `done` pulse come out together. A new request also arrives while the previous bundle is still being issued. The bench holds `instr_valid` high across back-to-back instructions of mixed modes, with a different mask and mode presented during the busy cycles. It then judges three things at the ports. The final slice must carry both the correct enables and `done`. The pending request must be held off until the cycle after `done`. The spacing between completion pulses must match the slice count plus one.

// File: rtl/ws_pkg.sv
package ws_pkg;

    typedef enum logic [0:0] {
        SEQ_IDLE  = 1'b0,
        SEQ_ISSUE = 1'b1
    } seq_state_e;

    typedef enum logic [0:0] {
        WK_FRAG = 1'b0,
        WK_VTX  = 1'b1
    } work_kind_e;

    // Number of clocks one instruction occupies for a bundle on a unit row.
    function automatic int slices_for(input int bundle, input int units);
        return bundle / units;
    endfunction

    // Counter width able to hold indices 0 .. n-1 (at least one bit).
    function automatic int idx_bits(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/ws_issue_ctrl.sv
module ws_issue_ctrl
    import ws_pkg::*;
#(
    parameter int FRAG_SLICES = 4,
    parameter int VTX_SLICES  = 2,
    parameter int IDX_W       = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             instr_valid,
    input  logic             vtx_mode,
    output logic             instr_ready,
    output logic             accept,
    output logic             issuing,
    output logic [IDX_W-1:0] slice_idx,
    output logic             last_slice
);

    localparam logic [IDX_W-1:0] FRAG_LAST = IDX_W'(FRAG_SLICES - 1);
    localparam logic [IDX_W-1:0] VTX_LAST  = IDX_W'(VTX_SLICES - 1);

    seq_state_e       state_q;
    work_kind_e       kind_q;
    logic [IDX_W-1:0] cnt_q;
    logic [IDX_W-1:0] last_cnt;

    assign instr_ready = (state_q == SEQ_IDLE);
    assign accept      = instr_ready & instr_valid;
    assign issuing     = (state_q == SEQ_ISSUE);
    assign last_cnt    = (kind_q == WK_VTX) ? VTX_LAST : FRAG_LAST;
    assign last_slice  = issuing & (cnt_q == last_cnt);
    assign slice_idx   = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            kind_q  <= WK_FRAG;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (accept) begin
                        state_q <= SEQ_ISSUE;
                        kind_q  <= vtx_mode ? WK_VTX : WK_FRAG;
                        cnt_q   <= '0;
                    end
                end
                SEQ_ISSUE: begin
                    if (last_slice) begin
                        state_q <= SEQ_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    state_q <= SEQ_IDLE;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/ws_mask_hold.sv
module ws_mask_hold #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] mask_in,
    output logic [W-1:0] mask_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (load) begin
            mask_q <= mask_in;
        end
    end

endmodule

// File: rtl/ws_lane_pick.sv
module ws_lane_pick #(
    parameter int UNITS  = 8,
    parameter int SLICES = 4,
    parameter int IDX_W  = 2
) (
    input  logic [UNITS*SLICES-1:0] mask_q,
    input  logic [IDX_W-1:0]        slice_idx,
    input  logic                    enable,
    output logic [UNITS-1:0]        lane_en
);

    logic [UNITS-1:0] slice_bits [SLICES];
    logic [UNITS-1:0] chosen;

    for (genvar s = 0; s < SLICES; s++) begin : g_slice
        assign slice_bits[s] = mask_q[s*UNITS +: UNITS];
    end

    always_comb begin
        chosen = '0;
        for (int s = 0; s < SLICES; s++) begin
            if (slice_idx == IDX_W'(s)) begin
                chosen = slice_bits[s];
            end
        end
    end

    for (genvar u = 0; u < UNITS; u++) begin : g_lane
        assign lane_en[u] = enable & chosen[u];
    end

endmodule

// File: rtl/ws_warp_issue_seq.sv
module ws_warp_issue_seq
    import ws_pkg::*;
#(
    parameter int UNITS       = 8,
    parameter int FRAG_BUNDLE = 32,
    parameter int VTX_BUNDLE  = 16,
    parameter int IDX_W       = idx_bits(slices_for(FRAG_BUNDLE, UNITS))
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   instr_valid,
    input  logic                   vtx_mode,
    input  logic [FRAG_BUNDLE-1:0] active_mask,
    output logic                   instr_ready,
    output logic                   slice_vld,
    output logic [IDX_W-1:0]       slice_idx,
    output logic [UNITS-1:0]       lane_en,
    output logic                   done
);

    localparam int FRAG_SLICES = slices_for(FRAG_BUNDLE, UNITS);
    localparam int VTX_SLICES  = slices_for(VTX_BUNDLE, UNITS);

    logic                   accept;
    logic                   issuing;
    logic                   last_slice;
    logic [FRAG_BUNDLE-1:0] mask_q;

    ws_issue_ctrl #(
        .FRAG_SLICES (FRAG_SLICES),
        .VTX_SLICES  (VTX_SLICES),
        .IDX_W       (IDX_W)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .instr_valid (instr_valid),
        .vtx_mode    (vtx_mode),
        .instr_ready (instr_ready),
        .accept      (accept),
        .issuing     (issuing),
        .slice_idx   (slice_idx),
        .last_slice  (last_slice)
    );

    ws_mask_hold #(
        .W (FRAG_BUNDLE)
    ) u_mask (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .mask_in (active_mask),
        .mask_q  (mask_q)
    );

    ws_lane_pick #(
        .UNITS  (UNITS),
        .SLICES (FRAG_SLICES),
        .IDX_W  (IDX_W)
    ) u_pick (
        .mask_q    (mask_q),
        .slice_idx (slice_idx),
        .enable    (issuing),
        .lane_en   (lane_en)
    );

    assign slice_vld = issuing;
    assign done      = last_slice;

endmodule

// File: rtl/ws_warp_issue_seq_chk.sv
module ws_warp_issue_seq_chk
    import ws_pkg::*;
#(
    parameter int UNITS       = 8,
    parameter int FRAG_BUNDLE = 32,
    parameter int VTX_BUNDLE  = 16,
    parameter int IDX_W       = 2
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   instr_valid,
    input logic                   vtx_mode,
    input logic [FRAG_BUNDLE-1:0] active_mask,
    input logic                   instr_ready,
    input logic                   slice_vld,
    input logic [IDX_W-1:0]       slice_idx,
    input logic [UNITS-1:0]       lane_en,
    input logic                   done
);

    localparam logic [IDX_W-1:0] FRAG_LAST = IDX_W'(slices_for(FRAG_BUNDLE, UNITS) - 1);
    localparam logic [IDX_W-1:0] VTX_LAST  = IDX_W'(slices_for(VTX_BUNDLE, UNITS) - 1);

    // Mode observed at the accepting edge, kept by the checker itself.
    logic seen_vtx;
    always_ff @(posedge clk) begin
        if (rst) begin
            seen_vtx <= 1'b0;
        end else if (instr_valid && instr_ready) begin
            seen_vtx <= vtx_mode;
        end
    end

    logic unused_mask;
    assign unused_mask = ^active_mask;

    assert_ready_low_R6: assert property (@(posedge clk) disable iff (rst)
        slice_vld |-> !instr_ready);

    assert_first_slice_R2: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && instr_ready) |=> (slice_vld && slice_idx == '0));

    assert_slice_step_R3: assert property (@(posedge clk) disable iff (rst)
        (slice_vld && !done) |=> (slice_vld && slice_idx == IDX_W'($past(slice_idx) + 1'b1)));

    assert_done_in_issue_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> slice_vld);

    assert_done_count_R4: assert property (@(posedge clk) disable iff (rst)
        done |-> (slice_idx == (seen_vtx ? VTX_LAST : FRAG_LAST)));

    assert_reopen_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> instr_ready);

    assert_quiet_lanes_R7: assert property (@(posedge clk) disable iff (rst)
        !slice_vld |-> (lane_en == '0));

endmodule

bind ws_warp_issue_seq ws_warp_issue_seq_chk #(
    .UNITS       (UNITS),
    .FRAG_BUNDLE (FRAG_BUNDLE),
    .VTX_BUNDLE  (VTX_BUNDLE),
    .IDX_W       (IDX_W)
) u_chk (.*);

// File: tb/ws_warp_issue_seq_bench.sv
module ws_warp_issue_seq_bench;

    localparam int UNITS = 8;
    localparam int FB    = 32;
    localparam int VB    = 16;
    localparam int IW    = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          instr_valid = 1'b0;
    logic          vtx_mode = 1'b0;
    logic [FB-1:0] active_mask = '0;
    logic          instr_ready;
    logic          slice_vld;
    logic [IW-1:0] slice_idx;
    logic [UNITS-1:0] lane_en;
    logic          done;

    always #2 clk = ~clk;

    ws_warp_issue_seq #(
        .UNITS (UNITS), .FRAG_BUNDLE (FB), .VTX_BUNDLE (VB), .IDX_W (IW)
    ) u_ws_warp_issue_seq (
        .clk (clk), .rst (rst), .instr_valid (instr_valid), .vtx_mode (vtx_mode),
        .active_mask (active_mask), .instr_ready (instr_ready), .slice_vld (slice_vld),
        .slice_idx (slice_idx), .lane_en (lane_en), .done (done)
    );

    typedef struct {
        int               idx;
        logic [UNITS-1:0] lanes;
        bit               last;
        string            req;
    } exp_t;

    exp_t exp_q[$];
    int   done_cyc[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    int   cyc    = 0;
    bit   mon_on = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Monitor: pops expected slices and compares as the design emits them.
    always @(negedge clk) begin
        if (mon_on && !rst) begin
            chk(instr_ready == !slice_vld, "R6", "ready vs busy", instr_ready, !slice_vld);
            if (slice_vld) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2", "unexpected slice", slice_idx, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(slice_idx == IW'(e.idx), e.req, "slice_idx", slice_idx, e.idx);
                    chk(lane_en == e.lanes, "R7", "lane_en", lane_en, e.lanes);
                    chk(done == e.last, "R5", "done", done, e.last);
                end
                if (done) done_cyc.push_back(cyc);
            end else begin
                chk(lane_en == '0, "R7", "idle lane_en", lane_en, 0);
                chk(done == 1'b0, "R5", "idle done", done, 0);
            end
        end
    end

    // Driver: offers an instruction, waits for acceptance, pushes expectation.
    task automatic send(input bit vtx, input logic [FB-1:0] m);
        int ns;
        @(negedge clk);
        instr_valid = 1'b1;
        vtx_mode    = vtx;
        active_mask = m;
        while (!instr_ready) @(negedge clk);
        ns = vtx ? VB / UNITS : FB / UNITS;
        for (int k = 0; k < ns; k++) begin
            exp_t e;
            e.idx   = k;
            e.lanes = m[k*UNITS +: UNITS];
            e.last  = (k == ns - 1);
            e.req   = vtx ? "R4" : "R3";
            exp_q.push_back(e);
        end
        @(posedge clk);
    endtask

    // Drop the request and disturb mode/mask while the bundle drains.
    task automatic drain();
        @(negedge clk);
        instr_valid = 1'b0;
        active_mask = ~active_mask ^ 32'h5A5A_0FF0;
        vtx_mode    = ~vtx_mode;
        while (exp_q.size() != 0 || slice_vld) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        // R1: state while reset is held
        chk(instr_ready == 1'b1, "R1", "ready in reset", instr_ready, 1);
        chk(slice_vld == 1'b0, "R1", "slice_vld in reset", slice_vld, 0);
        chk(lane_en == '0, "R1", "lane_en in reset", lane_en, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(done == 1'b0 && instr_ready, "R1", "after reset", {done, instr_ready}, 1);
        mon_on = 1'b1;

        // R3: fragment bundle, mixed mask
        send(1'b0, 32'hA5C3_0F81);
        drain();
        // R4: vertex bundle
        send(1'b1, 32'h1234_5678);
        drain();
        // R8: vertex with only upper mask bits set
        send(1'b1, 32'hFFFF_0000);
        drain();
        // R3: fragment, all active
        send(1'b0, 32'hFFFF_FFFF);
        drain();

        // R9: back-to-back fragments with valid held high
        done_cyc.delete();
        send(1'b0, 32'h0102_0408);
        send(1'b0, 32'h8040_2010);
        drain();
        chk(done_cyc.size() == 2, "R9", "done count", done_cyc.size(), 2);
        if (done_cyc.size() == 2)
            chk(done_cyc[1] - done_cyc[0] == 5, "R9", "frag gap", done_cyc[1] - done_cyc[0], 5);

        // R10: fragment then vertex; vertex mode is presented during the fragment issue
        done_cyc.delete();
        send(1'b0, 32'h7E7E_8181);
        send(1'b1, 32'hC3C3_3C3C);
        drain();
        if (done_cyc.size() == 2)
            chk(done_cyc[1] - done_cyc[0] == 3, "R10", "vtx after frag gap", done_cyc[1] - done_cyc[0], 3);
        else
            chk(1'b0, "R10", "done count", done_cyc.size(), 2);

        // R10: vertex then fragment
        done_cyc.delete();
        send(1'b1, 32'h0000_F00F);
        send(1'b0, 32'h1111_2222);
        drain();
        if (done_cyc.size() == 2)
            chk(done_cyc[1] - done_cyc[0] == 5, "R10", "frag after vtx gap", done_cyc[1] - done_cyc[0], 5);
        else
            chk(1'b0, "R10", "done count", done_cyc.size(), 2);

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R2", "leftover expectations", exp_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule